// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from power-on to the point where normal traffic may start. It holds the clock enable low and keeps the command bus idle until the supply and clock are reported stable. It then counts the mandatory settling wait, which is given in microseconds and converted to clock cycles from a clock-frequency parameter. After the wait it plays a fixed command script with the spacing each command needs. The script writes the extended mode register before the mode register, resets the DLL, precharges all banks, runs two refresh cycles and finishes with a second mode register write that leaves the DLL reset bit clear.

The mode register fields (burst length, burst ordering, CAS latency and output drive strength) come from parameters. The refresh cycle time is given in nanoseconds and is rounded up to whole cycles. A separate counter opens a window of a set number of cycles after the DLL reset. The done flag waits for both the end of the script and the end of that window, so a controller that starts reading as soon as done rises always respects the DLL lock time. A synchronous reset returns the block to its power-on state and the whole script runs again.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is high, and after it until power-stable is first sampled high, CKE is 0. The bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111). Bank address and address are 0 and done is 0.
- R2: The rising edge that first samples power-stable high is edge 1. CKE first reads 1 after edge WAIT_US*CLK_MHZ+1, and a NOP is on the bus in that cycle. While CKE is 0 the bus carries only NOP. Once CKE is high it stays high until reset.
- R3: After CKE rises, exactly seven non-NOP commands follow, in this order: PRECHARGE (0010), MODE LOAD (0000) with bank 01, MODE LOAD with bank 00, PRECHARGE, REFRESH (0001), REFRESH, MODE LOAD with bank 00.
- R4: Each PRECHARGE drives address bit 10 high, every other address bit 0 and bank 00, so that it closes all banks.
- R5: The extended mode load drives bit 0 = 0 (DLL enabled) and bit 1 = REDUCED_DRIVE. All other address bits are 0.
- R6: Both mode loads to bank 00 carry bits 2:0 = burst code (2→001, 4→010, 8→011), bit 3 = INTERLEAVE and bits 6:4 = CAS code (CAS_HALF 4→010, 5→110, 6→011). Bit 8 (DLL reset) is 1 on the first of them and 0 on the last. All other bits are 0.
- R7: The first PRECHARGE comes one cycle after CKE rises. The spacing from one command to the next is TRP_CYC after a PRECHARGE and TMRD_CYC after a mode load. After a REFRESH it is TRFC_CYC = max(2, ceil(TRFC_NS*CLK_MHZ/1000)).
- R8: Every cycle that carries no scripted command carries NOP with bank and address 0.
- R9: done first reads 1 in the later of two cycles: the final mode load + TMRD_CYC, and the DLL-reset mode load + DLL_CYC. From then on done stays 1 with CKE high and NOP on the bus until reset.
- R10: A synchronous reset in the middle of the script returns every output to the R1 state in the cycle after the edge that samples it. The full script then runs again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_stable_i | input | 1 | Supplies and clock are stable |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / mode value |
| done_o | output | 1 | Initialization complete |

## Verification
The bench builds the block with a 50 MHz clock and a 2 µs wait, which gives a 100-cycle wait instead of tens of thousands, so several full scripts fit in one run. A 3-cycle precharge time, a 2-cycle mode time, an 80 ns refresh time (4 cycles) and a 200-cycle DLL window make the DLL window the later of the two done conditions, so done timing tests the overlap rule. A burst of 4, CAS 2.5, interleaved ordering and reduced drive make every mode field nonzero, so each bit position is visible at the address pins.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [3:0] {
      CMD_MODE    = 4'b0000,
      CMD_REFRESH = 4'b0001,
      CMD_PRECHG  = 4'b0010,
      CMD_NOP     = 4'b0111
   } cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RUN,
      ST_FIN
   } seq_state_e;

   localparam int STEP_COUNT = 8;
   localparam int STEP_W     = 3;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrup_down_counter.sv
module pwrup_down_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pwrup_script.sv
module pwrup_script
   import pwrup_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int BA_W          = 2,
   parameter int GAP_W         = 4,
   parameter int TRP_CYC       = 3,
   parameter int TMRD_CYC      = 2,
   parameter int TRFC_CYC      = 15,
   parameter int BURST_LEN     = 4,
   parameter int CAS_HALF      = 5,
   parameter bit INTERLEAVE    = 1'b0,
   parameter bit REDUCED_DRIVE = 1'b0
) (
   input  logic [STEP_W-1:0] step_i,
   output cmd_e              cmd_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [GAP_W-1:0]  gap_o,
   output logic              dll_rst_o
);

   logic [2:0] bl_code;
   logic [2:0] cl_code;

   // Burst length field variant
   if (BURST_LEN == 2) begin : g_bl2
      assign bl_code = 3'b001;
   end else if (BURST_LEN == 4) begin : g_bl4
      assign bl_code = 3'b010;
   end else if (BURST_LEN == 8) begin : g_bl8
      assign bl_code = 3'b011;
   end else begin : g_bl_bad
      $error("pwrup_script: BURST_LEN must be 2, 4 or 8");
      assign bl_code = 3'b000;
   end

   // CAS latency field variant (latency in half cycles)
   if (CAS_HALF == 4) begin : g_cl2
      assign cl_code = 3'b010;
   end else if (CAS_HALF == 5) begin : g_cl25
      assign cl_code = 3'b110;
   end else if (CAS_HALF == 6) begin : g_cl3
      assign cl_code = 3'b011;
   end else begin : g_cl_bad
      $error("pwrup_script: CAS_HALF must be 4, 5 or 6");
      assign cl_code = 3'b000;
   end

   if (ADDR_W < 11) begin : g_addr_bad
      $error("pwrup_script: ADDR_W must be at least 11");
   end
   if (BA_W < 2) begin : g_ba_bad
      $error("pwrup_script: BA_W must be at least 2");
   end

   logic [ADDR_W-1:0] mode_ops;
   logic [ADDR_W-1:0] ext_ops;
   logic [ADDR_W-1:0] prechg_all;

   always_comb begin
      mode_ops      = '0;
      mode_ops[2:0] = bl_code;
      mode_ops[3]   = INTERLEAVE;
      mode_ops[6:4] = cl_code;
      ext_ops       = '0;
      ext_ops[0]    = 1'b0;            // DLL enabled
      ext_ops[1]    = REDUCED_DRIVE;
      prechg_all    = '0;
      prechg_all[10] = 1'b1;
   end

   always_comb begin
      cmd_o     = CMD_NOP;
      ba_o      = '0;
      addr_o    = '0;
      dll_rst_o = 1'b0;
      unique case (step_i)
         3'd0: cmd_o = CMD_NOP;
         3'd1: begin
            cmd_o  = CMD_PRECHG;
            addr_o = prechg_all;
         end
         3'd2: begin
            cmd_o  = CMD_MODE;
            ba_o   = BA_W'(1);
            addr_o = ext_ops;
         end
         3'd3: begin
            cmd_o     = CMD_MODE;
            addr_o    = mode_ops;
            addr_o[8] = 1'b1;
            dll_rst_o = 1'b1;
         end
         3'd4: begin
            cmd_o  = CMD_PRECHG;
            addr_o = prechg_all;
         end
         3'd5: cmd_o = CMD_REFRESH;
         3'd6: cmd_o = CMD_REFRESH;
         default: begin
            cmd_o  = CMD_MODE;
            addr_o = mode_ops;
         end
      endcase
   end

   always_comb begin
      unique case (cmd_o)
         CMD_PRECHG:  gap_o = GAP_W'(TRP_CYC);
         CMD_MODE:    gap_o = GAP_W'(TMRD_CYC);
         CMD_REFRESH: gap_o = GAP_W'(TRFC_CYC);
         default:     gap_o = GAP_W'(1);
      endcase
   end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
   import pwrup_pkg::*;
#(
   parameter int CLK_MHZ       = 200,
   parameter int WAIT_US       = 200,
   parameter int TRP_CYC       = 3,
   parameter int TMRD_CYC      = 2,
   parameter int TRFC_NS       = 75,
   parameter int DLL_CYC       = 200,
   parameter int ADDR_W        = 13,
   parameter int BA_W          = 2,
   parameter int BURST_LEN     = 4,
   parameter int CAS_HALF      = 5,
   parameter bit INTERLEAVE    = 1'b0,
   parameter bit REDUCED_DRIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pwr_stable_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              done_o
);

   localparam int WAIT_CYC = WAIT_US * CLK_MHZ;
   localparam int TRFC_CYC = imax(2, ceil_div(TRFC_NS * CLK_MHZ, 1000));
   localparam int GAP_MAX  = imax(imax(TRP_CYC, TMRD_CYC), TRFC_CYC);
   localparam int GAP_W    = $clog2(GAP_MAX + 1);
   localparam int TMR_W    = $clog2(imax(WAIT_CYC, GAP_MAX) + 1);
   localparam int DLL_W    = $clog2(DLL_CYC + 1);

   if (WAIT_CYC < 1 || TRP_CYC < 1 || TMRD_CYC < 1 || DLL_CYC < 1) begin : g_time_bad
      $error("sdram_powerup_seq: every wait must be at least one cycle");
   end

   seq_state_e        state_q;
   logic [STEP_W-1:0] idx_q;
   logic              cke_q;
   cmd_e              cmd_q;
   logic [BA_W-1:0]   ba_q;
   logic [ADDR_W-1:0] addr_q;

   logic [STEP_W-1:0] scr_idx;
   cmd_e              scr_cmd;
   logic [BA_W-1:0]   scr_ba;
   logic [ADDR_W-1:0] scr_addr;
   logic [GAP_W-1:0]  scr_gap;
   logic              scr_dll_rst;

   logic              tmr_load, tmr_zero;
   logic [TMR_W-1:0]  tmr_val;
   logic              dll_load, dll_zero;
   logic              start, issue, finish, cur_last;

   assign scr_idx  = (state_q == ST_WAIT) ? '0 : idx_q + 3'd1;
   assign cur_last = (idx_q == STEP_W'(STEP_COUNT - 1));

   pwrup_script #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_W(GAP_W),
      .TRP_CYC(TRP_CYC), .TMRD_CYC(TMRD_CYC), .TRFC_CYC(TRFC_CYC),
      .BURST_LEN(BURST_LEN), .CAS_HALF(CAS_HALF),
      .INTERLEAVE(INTERLEAVE), .REDUCED_DRIVE(REDUCED_DRIVE)
   ) u_script (
      .step_i   (scr_idx),
      .cmd_o    (scr_cmd),
      .ba_o     (scr_ba),
      .addr_o   (scr_addr),
      .gap_o    (scr_gap),
      .dll_rst_o(scr_dll_rst)
   );

   always_comb begin
      start    = (state_q == ST_IDLE) && pwr_stable_i;
      issue    = tmr_zero && ((state_q == ST_WAIT) ||
                              ((state_q == ST_RUN) && !cur_last));
      finish   = tmr_zero && (state_q == ST_RUN) && cur_last;
      tmr_load = start || issue;
      tmr_val  = start ? TMR_W'(WAIT_CYC - 1)
                       : (TMR_W'(scr_gap) - TMR_W'(1));
      dll_load = issue && scr_dll_rst;
   end

   pwrup_down_counter #(.W(TMR_W)) u_step_timer (
      .clk   (clk),
      .rst   (rst),
      .load_i(tmr_load),
      .val_i (tmr_val),
      .zero_o(tmr_zero)
   );

   pwrup_down_counter #(.W(DLL_W)) u_dll_timer (
      .clk   (clk),
      .rst   (rst),
      .load_i(dll_load),
      .val_i (DLL_W'(DLL_CYC)),
      .zero_o(dll_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         cke_q   <= 1'b0;
         cmd_q   <= CMD_NOP;
         ba_q    <= '0;
         addr_q  <= '0;
      end else begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         if (start) begin
            state_q <= ST_WAIT;
         end else if (issue) begin
            state_q <= ST_RUN;
            idx_q   <= scr_idx;
            cke_q   <= 1'b1;
            cmd_q   <= scr_cmd;
            ba_q    <= scr_ba;
            addr_q  <= scr_addr;
         end else if (finish) begin
            state_q <= ST_FIN;
         end
      end
   end

   assign cke_o = cke_q;
   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
   assign ba_o   = ba_q;
   assign addr_o = addr_q;
   assign done_o = (state_q == ST_FIN) && dll_zero;

   AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
      !cke_q |-> cmd_q == CMD_NOP) else $error("cmd with cke low"); // R2
   AST_CKE_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
      cke_q |=> cke_q) else $error("cke fell"); // R2
   AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (rst)
      cmd_q == CMD_PRECHG |-> addr_q[10] && ba_q == '0) else $error("precharge not all"); // R4
   AST_REFRESH_GAP: assert property (@(posedge clk) disable iff (rst)
      cmd_q == CMD_REFRESH |=> cmd_q == CMD_NOP) else $error("refresh gap"); // R7
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      done_o |=> done_o) else $error("done dropped"); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      done_o |-> cmd_q == CMD_NOP && cke_q) else $error("busy after done"); // R9

endmodule

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;

   localparam int CLK_MHZ  = 50;
   localparam int WAIT_US  = 2;
   localparam int TRP      = 3;
   localparam int TMRD     = 2;
   localparam int TRFC_NS  = 80;
   localparam int DLL      = 200;
   localparam int WAIT_CYC = WAIT_US * CLK_MHZ;   // 100
   localparam int TRFC     = 4;                   // ceil(80*50/1000)
   localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
   // burst 4 -> 010, interleave -> bit3, CAS 2.5 -> 110 in bits 6:4
   localparam logic [12:0] MR_OPS = 13'h06A;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pwr_stable = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, done;
   logic [1:0]  ba;
   logic [12:0] addr;

   int errors = 0;
   int checks = 0;

   logic [3:0]  rc_cmd [16];
   logic [1:0]  rc_ba  [16];
   logic [12:0] rc_addr[16];
   int          rc_cyc [16];
   int ncmd, cke_rise, done_at, nop_bad;
   logic [3:0] cmd_at_rise;

   always #10 clk = ~clk;

   sdram_powerup_seq #(
      .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
      .TRFC_NS(TRFC_NS), .DLL_CYC(DLL), .ADDR_W(13), .BA_W(2),
      .BURST_LEN(4), .CAS_HALF(5), .INTERLEAVE(1'b1), .REDUCED_DRIVE(1'b1)
   ) uut (
      .clk(clk), .rst(rst), .pwr_stable_i(pwr_stable),
      .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
      .ba_o(ba), .addr_o(addr), .done_o(done)
   );

   function automatic logic [3:0] bus();
      return {cs_n, ras_n, cas_n, we_n};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(cke == 1'b0, req, "cke", int'(cke), 0);
      check(bus() == NOP && ba == 2'b0 && addr == 13'b0, req, "bus idle",
            int'({bus(), ba, addr}), int'({NOP, 15'b0}));
      check(done == 1'b0, req, "done", int'(done), 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      pwr_stable = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic capture(input int limit);
      ncmd = 0; cke_rise = -1; done_at = -1; nop_bad = 0; cmd_at_rise = 4'hF;
      pwr_stable = 1'b1;
      for (int n = 1; n <= limit; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (!cke && bus() != NOP) nop_bad++;
         if (cke_rise >= 0 && !cke) nop_bad++;
         if (cke && cke_rise < 0) begin
            cke_rise = n;
            cmd_at_rise = bus();
         end
         if (bus() != NOP) begin
            if (ncmd < 16) begin
               rc_cmd[ncmd] = bus(); rc_ba[ncmd] = ba;
               rc_addr[ncmd] = addr; rc_cyc[ncmd] = n;
            end
            ncmd++;
         end else if (ba != 2'b0 || addr != 13'b0) begin
            nop_bad++;   // R8: idle cycles carry zero address
         end
         if (done && done_at < 0) begin
            done_at = n;
            break;
         end
      end
   endtask

   task automatic check_script(input string tag);
      logic [3:0]  ecmd [7];
      logic [1:0]  eba  [7];
      logic [12:0] eadr [7];
      int          ecyc [7];
      int          edone;
      ecmd = '{PRE, MRS, MRS, PRE, REF, REF, MRS};
      eba  = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
      eadr = '{13'h400, 13'h002, MR_OPS | 13'h100, 13'h400, 13'h0, 13'h0, MR_OPS};
      ecyc[0] = WAIT_CYC + 2;
      ecyc[1] = ecyc[0] + TRP;
      ecyc[2] = ecyc[1] + TMRD;
      ecyc[3] = ecyc[2] + TMRD;
      ecyc[4] = ecyc[3] + TRP;
      ecyc[5] = ecyc[4] + TRFC;
      ecyc[6] = ecyc[5] + TRFC;
      edone = (ecyc[6] + TMRD > ecyc[2] + DLL) ? ecyc[6] + TMRD : ecyc[2] + DLL;

      check(cke_rise == WAIT_CYC + 1, {tag, "/R2"}, "cke rise edge", cke_rise, WAIT_CYC + 1);
      check(cmd_at_rise == NOP, {tag, "/R2"}, "cmd at cke rise", int'(cmd_at_rise), int'(NOP));
      check(nop_bad == 0, {tag, "/R8"}, "stray bus cycles", nop_bad, 0);
      check(ncmd == 7, {tag, "/R3"}, "command count", ncmd, 7);
      for (int i = 0; i < 7; i++) begin
         check(rc_cmd[i] == ecmd[i] && rc_ba[i] == eba[i], {tag, "/R3"},
               $sformatf("cmd/bank %0d", i), int'({rc_cmd[i], rc_ba[i]}), int'({ecmd[i], eba[i]}));
         check(rc_addr[i] == eadr[i],
               (i == 1) ? {tag, "/R5"} : (i == 0 || i == 3) ? {tag, "/R4"} : {tag, "/R6"},
               $sformatf("addr %0d", i), int'(rc_addr[i]), int'(eadr[i]));
         check(rc_cyc[i] == ecyc[i], {tag, "/R7"}, $sformatf("cycle %0d", i), rc_cyc[i], ecyc[i]);
      end
      check(done_at == edone, {tag, "/R9"}, "done cycle", done_at, edone);
   endtask

   task automatic test_reset_state();
      do_reset();
      check_idle("R1");
      repeat (20) @(posedge clk);
      @(negedge clk);
      check_idle("R1");
   endtask

   task automatic test_full_script();
      capture(2000);
      check_script("full");
      for (int k = 0; k < 30; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (!(done && cke && bus() == NOP)) begin
            check(1'b0, "R9", "done hold", int'({done, cke, bus()}), int'({2'b11, NOP}));
            break;
         end
      end
      check(done && cke, "R9", "done after hold", int'(done), 1);
   endtask

   task automatic test_mid_reset();
      do_reset();
      pwr_stable = 1'b1;
      repeat (WAIT_CYC + 6) @(posedge clk);
      @(negedge clk);
      check(cke == 1'b1, "R10", "cke before reset", int'(cke), 1);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_idle("R10");
      rst = 1'b0;
      pwr_stable = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check_idle("R1");
      capture(2000);
      check_script("R10");
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      test_reset_state();
      test_full_script();
      test_mid_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule